// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the host-facing register bank of a disk controller. It is byte-wide and sits behind a 3-bit address. It holds the addressing registers that the host loads before issuing a command: sector count, start sector, cylinder low and high, drive/head and feature. It also builds the status byte from a few flags supplied by the neighbouring data-path block. Reads are combinational on `bus_rdata`. Side effects of a read, and all writes, take effect at the clock edge on which `bus_sel` is sampled high.

A byte written to the command offset is classified at once:

- Housekeeping commands complete immediately.
- Commands that move data go to the neighbouring block as a one-cycle strobe with the command code.
- Unsupported or impossible commands set the abort bit of the error register.

Completion interrupts are not raised directly. A small countdown is loaded instead, and it runs on an external tick strobe. A read of the main status register acknowledges and cancels the interrupt. A separate alternate-status output shows the same status byte but has no side effect.

Top module: `atf_taskfile`

## Requirements
- R1: After reset, every stored register reads 0x00, the error register reads 0x00, `irq` is low and `xfer_go` is low.
- R2: Offsets 2, 3, 4 and 5 are plain read/write bytes (count, sector, cylinder low, cylinder high). A write to offset 1 loads the feature register, and a read of offset 1 returns the error register instead. Offset 0 reads 0x00 and ignores writes.
- R3: A write to offset 6 stores bits 7:6 as a size code, bit 5 as an LBA flag, bit 4 as drive select and bits 3:0 as head. A read of offset 6 returns the same fields in the same positions. The drive-select bit picks which bit of `drive_present` the status byte uses.
- R4: In the status byte, bits 6 and 4 are set when the selected drive is present. Bit 3 is set when `buf_nonempty` or `wr_pending` is high. Bit 0 is set when the error register is nonzero. All other bits are 0.
- R5: A read of offset 1 returns the error value, and the error register is 0x00 from the next cycle on.
- R6: Any command written while the selected drive is absent sets error bit 2 (abort, 0x04), schedules an interrupt and is not forwarded.
- R7: Commands 0x10, 0x91 and 0xE1 leave the error register unchanged and schedule an interrupt.
- R8: A command code that no other requirement lists sets abort and schedules no interrupt.
- R9: Codes 0xF1 through 0xF6 and 0xA1 set abort and schedule no interrupt.
- R10: Command 0xEF always schedules an interrupt. It sets abort unless the feature register holds 0x03.
- R11: Commands 0x20, 0x30 and 0xEC pulse `xfer_go` for exactly one cycle, with `xfer_cmd` holding the code. They do not set abort. 0x20 and 0xEC schedule an interrupt and 0x30 does not.
- R12: A scheduled interrupt loads a countdown with `IRQ_DELAY` (default 1). `irq` rises at the edge where a `tick` strobe brings the count to zero. `irq` then stays high until it is acknowledged.
- R13: A read of offset 7 lowers `irq` and cancels a pending countdown. `alt_status` always equals the status byte and reading it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe for the eight-offset window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| alt_status | output | 8 | Alternate status byte, free of side effects |
| tick | input | 1 | Single-cycle timebase strobe for the interrupt countdown |
| drive_present | input | 2 | Presence flag per drive select value |
| buf_nonempty | input | 1 | Transfer buffer holds data |
| wr_pending | input | 1 | A write transfer awaits data |
| xfer_go | output | 1 | One-cycle strobe for a forwarded transfer command |
| xfer_cmd | output | 8 | Code of the last forwarded command |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples `bus_rdata` in the same cycle as the read strobe. Written registers, the error update, `xfer_go` and the countdown load are all due one edge after the write. The bench therefore checks them at the falling edge that follows that write edge. `irq` is due at the edge that samples the counting tick, and is checked at the falling edge after the tick pulse. Every absence check (no interrupt, no forward) is made after a tick has been given, so a scheduled interrupt would already have appeared.

// File: rtl/atf_pkg.sv
package atf_pkg;
   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_ERR  = 3'd1;
   localparam logic [2:0] OFS_SDH  = 3'd6;
   localparam logic [2:0] OFS_CMD  = 3'd7;

   localparam int ST_DRDY = 6;
   localparam int ST_DSC  = 4;
   localparam int ST_DRQ  = 3;
   localparam int ST_ERR  = 0;
   localparam int ER_ABRT = 2;

   localparam logic [7:0] CMD_RECAL     = 8'h10;
   localparam logic [7:0] CMD_RD_SECT   = 8'h20;
   localparam logic [7:0] CMD_WR_SECT   = 8'h30;
   localparam logic [7:0] CMD_INIT_PARM = 8'h91;
   localparam logic [7:0] CMD_PKT_ID    = 8'hA1;
   localparam logic [7:0] CMD_IDLE_NOW  = 8'hE1;
   localparam logic [7:0] CMD_IDENT     = 8'hEC;
   localparam logic [7:0] CMD_SET_FEAT  = 8'hEF;
   localparam logic [7:0] FEAT_XFER     = 8'h03;

   typedef enum logic [2:0] {
      CK_IMMED,
      CK_FEATURE,
      CK_XFER_IRQ,
      CK_XFER_QUIET,
      CK_REJECT,
      CK_UNKNOWN
   } cmd_kind_e;

   typedef struct packed {
      logic [1:0] ssz;
      logic       lba;
      logic       drv;
      logic [3:0] head;
   } sdh_t;
endpackage

// File: rtl/atf_regfile.sv
module atf_regfile
   import atf_pkg::*;
#(
   parameter int N_PLAIN = 4,
   parameter int PLAIN_BASE = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [2:0]              addr,
   input  logic [7:0]              wdata,
   output logic [N_PLAIN-1:0][7:0] plain_o,
   output sdh_t                    sdh_o,
   output logic [7:0]              feature_o
);
   initial begin
      assert_param_layout_R2: assert (PLAIN_BASE + N_PLAIN <= 6 && PLAIN_BASE >= 2)
         else $error("plain registers overlap fixed offsets");
   end

   for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
      localparam logic [2:0] MY_OFS = 3'(g + PLAIN_BASE);
      always_ff @(posedge clk) begin
         if (!rst_n)
            plain_o[g] <= 8'h00;
         else if (wr_en && addr == MY_OFS)
            plain_o[g] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sdh_o     <= '0;
         feature_o <= 8'h00;
      end else if (wr_en) begin
         if (addr == OFS_SDH) sdh_o     <= sdh_t'(wdata);
         if (addr == OFS_ERR) feature_o <= wdata;
      end
   end

   assert_sdh_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_SDH) |=> (sdh_o == sdh_t'($past(wdata))));
endmodule

// File: rtl/atf_cmd_decode.sv
module atf_cmd_decode
   import atf_pkg::*;
(
   input  logic [7:0] cmd,
   input  logic [7:0] feature,
   input  logic       drive_ok,
   output logic       set_abort,
   output logic       sched_irq,
   output logic       fwd
);
   cmd_kind_e kind;

   always_comb begin
      case (cmd) inside
         CMD_RECAL, CMD_INIT_PARM, CMD_IDLE_NOW: kind = CK_IMMED;
         CMD_SET_FEAT:                           kind = CK_FEATURE;
         CMD_RD_SECT, CMD_IDENT:                 kind = CK_XFER_IRQ;
         CMD_WR_SECT:                            kind = CK_XFER_QUIET;
         [8'hF1:8'hF6], CMD_PKT_ID:              kind = CK_REJECT;
         default:                                kind = CK_UNKNOWN;
      endcase
   end

   always_comb begin
      set_abort = 1'b0;
      sched_irq = 1'b0;
      fwd       = 1'b0;
      if (!drive_ok) begin
         set_abort = 1'b1;
         sched_irq = 1'b1;
      end else begin
         case (kind)
            CK_IMMED:      sched_irq = 1'b1;
            CK_FEATURE: begin
               sched_irq = 1'b1;
               set_abort = (feature != FEAT_XFER);
            end
            CK_XFER_IRQ: begin
               fwd       = 1'b1;
               sched_irq = 1'b1;
            end
            CK_XFER_QUIET: fwd = 1'b1;
            default:       set_abort = 1'b1;
         endcase
      end
   end

   always_comb begin
      assert_fwd_excl_abort_R11: assert (!(fwd && set_abort));
   end
endmodule

// File: rtl/atf_irq_timer.sv
module atf_irq_timer #(
   parameter int IRQ_DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sched,
   input  logic cancel,
   input  logic tick,
   output logic irq
);
   localparam int CNT_W = (IRQ_DELAY > 1) ? $clog2(IRQ_DELAY + 1) : 1;

   initial begin
      assert_param_delay_R12: assert (IRQ_DELAY >= 0 && IRQ_DELAY < 65536)
         else $error("IRQ_DELAY out of range");
   end

   if (IRQ_DELAY == 0) begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n)      irq <= 1'b0;
         else if (cancel) irq <= 1'b0;
         else if (sched)  irq <= 1'b1;
      end
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
         end else if (cancel) begin
            cnt <= '0;
            irq <= 1'b0;
         end else if (sched) begin
            cnt <= CNT_W'(IRQ_DELAY);
         end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) irq <= 1'b1;
         end
      end

      assert_rise_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq) |-> $past(tick));
      assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (irq && !cancel) |=> irq);
   end

   assert_cancel_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !irq);
endmodule

// File: rtl/atf_taskfile.sv
module atf_taskfile
   import atf_pkg::*;
#(
   parameter int IRQ_DELAY = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic [7:0] alt_status,
   input  logic       tick,
   input  logic [1:0] drive_present,
   input  logic       buf_nonempty,
   input  logic       wr_pending,
   output logic       xfer_go,
   output logic [7:0] xfer_cmd,
   output logic       irq
);
   localparam int N_PLAIN = 4;
   localparam int PLAIN_BASE = 2;

   logic                    wr_acc, rd_acc, cmd_wr, err_rd, stat_rd;
   logic [N_PLAIN-1:0][7:0] plain;
   sdh_t                    sdh;
   logic [7:0]              feature, err_q, status;
   logic                    drive_ok, set_abort, sched_irq, fwd;

   assign wr_acc  = bus_sel && bus_wr;
   assign rd_acc  = bus_sel && !bus_wr;
   assign cmd_wr  = wr_acc && bus_addr == OFS_CMD;
   assign err_rd  = rd_acc && bus_addr == OFS_ERR;
   assign stat_rd = rd_acc && bus_addr == OFS_CMD;

   atf_regfile #(.N_PLAIN(N_PLAIN), .PLAIN_BASE(PLAIN_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .addr(bus_addr),
      .wdata(bus_wdata), .plain_o(plain), .sdh_o(sdh), .feature_o(feature)
   );

   assign drive_ok = drive_present[sdh.drv];

   atf_cmd_decode u_dec (
      .cmd(bus_wdata), .feature(feature), .drive_ok(drive_ok),
      .set_abort(set_abort), .sched_irq(sched_irq), .fwd(fwd)
   );

   atf_irq_timer #(.IRQ_DELAY(IRQ_DELAY)) u_tmr (
      .clk(clk), .rst_n(rst_n), .sched(cmd_wr && sched_irq),
      .cancel(stat_rd), .tick(tick), .irq(irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 8'h00;
      end else if (cmd_wr && set_abort) begin
         err_q[ER_ABRT] <= 1'b1;
      end else if (err_rd) begin
         err_q <= 8'h00;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_go  <= 1'b0;
         xfer_cmd <= 8'h00;
      end else begin
         xfer_go <= cmd_wr && fwd;
         if (cmd_wr && fwd) xfer_cmd <= bus_wdata;
      end
   end

   always_comb begin
      status          = 8'h00;
      status[ST_DRDY] = drive_ok;
      status[ST_DSC]  = drive_ok;
      status[ST_DRQ]  = buf_nonempty || wr_pending;
      status[ST_ERR]  = (err_q != 8'h00);
   end

   assign alt_status = status;

   always_comb begin
      case (bus_addr)
         OFS_DATA: bus_rdata = 8'h00;
         OFS_ERR:  bus_rdata = err_q;
         OFS_SDH:  bus_rdata = sdh;
         OFS_CMD:  bus_rdata = status;
         default:  bus_rdata = plain[bus_addr - 3'(PLAIN_BASE)];
      endcase
   end

   assert_err_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rd && !cmd_wr) |=> (err_q == 8'h00));
   assert_abort_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && set_abort) |=> err_q[ER_ABRT]);
   assert_go_from_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |-> $past(cmd_wr));
   assert_err_only_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(err_q) <= 1);
endmodule

// File: tb/sim_atf_taskfile.sv
module sim_atf_taskfile;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, tick = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata, alt_status, xfer_cmd;
   logic [1:0] drive_present = 2'b00;
   logic       buf_nonempty = 1'b0, wr_pending = 1'b0;
   logic       xfer_go, irq;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   atf_taskfile u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .alt_status(alt_status), .tick(tick), .drive_present(drive_present),
      .buf_nonempty(buf_nonempty), .wr_pending(wr_pending),
      .xfer_go(xfer_go), .xfer_cmd(xfer_cmd), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
      logic [7:0] v;
      rd(a, v);
      chk(v === e, tag, v, e);
   endtask

   task automatic t_reset();
      chk(irq === 1'b0, "R1 irq after reset", irq, 0);
      chk(xfer_go === 1'b0, "R1 xfer_go after reset", xfer_go, 0);
      for (int a = 1; a < 7; a++) expect_rd(3'(a), 8'h00, "R1 register after reset");
      expect_rd(3'd7, 8'h00, "R1 status after reset");
   endtask

   task automatic t_regs();
      wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h44);
      expect_rd(3'd2, 8'h11, "R2 count");
      expect_rd(3'd3, 8'h22, "R2 sector");
      expect_rd(3'd4, 8'h33, "R2 cyl low");
      expect_rd(3'd5, 8'h44, "R2 cyl high");
      wr(3'd1, 8'h5A);
      expect_rd(3'd1, 8'h00, "R2 feature write not seen on error read");
      wr(3'd0, 8'hFF);
      expect_rd(3'd0, 8'h00, "R2 data offset");
      expect_rd(3'd2, 8'h11, "R2 count unchanged by data write");
   endtask

   task automatic t_sdh_status();
      drive_present = 2'b10;
      wr(3'd6, 8'hB5);
      expect_rd(3'd6, 8'hB5, "R3 drive/head packing");
      chk(alt_status === 8'h50, "R3 R4 drive 1 present", alt_status, 8'h50);
      wr(3'd6, 8'h4A);
      expect_rd(3'd6, 8'h4A, "R3 drive/head packing 2");
      chk(alt_status === 8'h00, "R3 R4 drive 0 absent", alt_status, 8'h00);
      drive_present = 2'b01;
      #1 chk(alt_status === 8'h50, "R4 drive 0 present", alt_status, 8'h50);
      buf_nonempty = 1'b1;
      #1 chk(alt_status === 8'h58, "R4 buffer DRQ", alt_status, 8'h58);
      buf_nonempty = 1'b0; wr_pending = 1'b1;
      #1 chk(alt_status === 8'h58, "R4 write pending DRQ", alt_status, 8'h58);
      wr_pending = 1'b0;
   endtask

   task automatic t_absent();
      drive_present = 2'b00;
      wr(3'd7, 8'h10);
      chk(irq === 1'b0, "R12 no irq before tick", irq, 0);
      repeat (3) @(negedge clk);
      chk(irq === 1'b0, "R12 no irq without tick", irq, 0);
      pulse_tick();
      chk(irq === 1'b1, "R6 R12 irq after tick", irq, 1);
      chk(alt_status === 8'h01, "R4 R6 ERR bit", alt_status, 8'h01);
      @(negedge clk);
      chk(irq === 1'b1, "R13 alt status leaves irq", irq, 1);
      expect_rd(3'd7, 8'h01, "R13 main status byte");
      chk(irq === 1'b0, "R13 status read clears irq", irq, 0);
      expect_rd(3'd1, 8'h04, "R6 abort bit");
      expect_rd(3'd1, 8'h00, "R5 error cleared by read");
      chk(alt_status === 8'h00, "R5 ERR bit gone", alt_status, 8'h00);
   endtask

   task automatic t_immed();
      logic [7:0] codes [3] = '{8'h10, 8'h91, 8'hE1};
      drive_present = 2'b11;
      foreach (codes[i]) begin
         wr(3'd7, codes[i]);
         chk(xfer_go === 1'b0, "R7 not forwarded", xfer_go, 0);
         pulse_tick();
         chk(irq === 1'b1, "R7 irq", irq, 1);
         expect_rd(3'd7, 8'h50, "R7 status no error");
         expect_rd(3'd1, 8'h00, "R7 error clean");
      end
   endtask

   task automatic t_cancel();
      wr(3'd7, 8'h91);
      expect_rd(3'd7, 8'h50, "R13 status read before tick");
      pulse_tick();
      chk(irq === 1'b0, "R13 countdown cancelled", irq, 0);
   endtask

   task automatic t_reject();
      logic [7:0] codes [4] = '{8'h55, 8'hF1, 8'hF6, 8'hA1};
      foreach (codes[i]) begin
         wr(3'd7, codes[i]);
         pulse_tick();
         chk(irq === 1'b0, (i == 0) ? "R8 unknown no irq" : "R9 rejected no irq", irq, 0);
         expect_rd(3'd1, 8'h04, (i == 0) ? "R8 unknown abort" : "R9 rejected abort");
      end
   endtask

   task automatic t_feature();
      wr(3'd1, 8'h03);
      wr(3'd7, 8'hEF);
      pulse_tick();
      chk(irq === 1'b1, "R10 good feature irq", irq, 1);
      expect_rd(3'd1, 8'h00, "R10 good feature no abort");
      expect_rd(3'd7, 8'h50, "R10 ack");
      wr(3'd1, 8'h02);
      wr(3'd7, 8'hEF);
      pulse_tick();
      chk(irq === 1'b1, "R10 bad feature irq", irq, 1);
      expect_rd(3'd7, 8'h51, "R10 bad feature ERR");
      expect_rd(3'd1, 8'h04, "R10 bad feature abort");
   endtask

   task automatic t_xfer();
      logic [7:0] codes [3] = '{8'h20, 8'h30, 8'hEC};
      foreach (codes[i]) begin
         wr(3'd7, codes[i]);
         chk(xfer_go === 1'b1, "R11 go pulse", xfer_go, 1);
         chk(xfer_cmd === codes[i], "R11 forwarded code", xfer_cmd, codes[i]);
         @(negedge clk);
         chk(xfer_go === 1'b0, "R11 go single cycle", xfer_go, 0);
         pulse_tick();
         chk(irq === (codes[i] != 8'h30), "R11 irq per code", irq, codes[i] != 8'h30);
         expect_rd(3'd1, 8'h00, "R11 no abort");
         expect_rd(3'd7, 8'h50, "R11 ack");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_sdh_status();
      t_absent();
      t_immed();
      t_cancel();
      t_reject();
      t_feature();
      t_xfer();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1..: actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule